// File: doc/BRIEF.md
# Synchronous Hunt and Sync Detector

This block is the character-framing front end of a synchronous serial receiver. Serial data arrives one bit per receive-clock rising edge, presented to the block as a one-cycle bit strobe in the system clock domain. While hunting, the block slides a window over the incoming bits and compares it, bit by bit, with one programmed sync character, or with two that must arrive back to back. A match ends the hunt and fixes the character boundaries. Instead of matching internally, the block can take its framing from an external sync input.

Once framed, the block assembles a character every (length + parity) bits. It delivers each character with a one-cycle ready pulse and a parity error flag. It also keeps watching for the sync pattern, but only at the known boundaries. A sticky sync-detect flag reports every detection, and a status-read pulse clears it. An enter-hunt pulse drops framing and refills the window with ones, so a half-received pattern from before cannot complete a false match.

Top module: `sync_hunt_rx`

## Requirements
- R1: While `rst_n` is low, `in_hunt` is 1, `sync_det` is 0 and `char_vld` is 0.
- R2: A `hunt_req` pulse takes priority over a bit strobe in the same cycle. It sets `in_hunt` on the next clock and loads every used window bit with 1, so bits received before the pulse cannot complete a sync match afterwards.
- R3: In hunt with internal sync, the window is compared with `sync1` after every bit strobe. Bit 0 of the character is the oldest bit in the window, since the character is sent LSB first.
- R4: With `one_sync` = 0, `sync2` must fill exactly the next (length + parity) bits after `sync1`. If it does not, hunting resumes. If that character is itself `sync1`, it starts a fresh wait for `sync2`.
- R5: `sync_det` and the end of hunt take effect one clock after the strobe of the last bit of the final sync character. That last bit is the last data bit, or the parity bit when `par_en` = 1.
- R6: A `stat_rd` pulse in a cycle without a bit strobe clears `sync_det` on the next clock and leaves `in_hunt` unchanged.
- R7: Once framed, every (length + parity) bits raise `char_vld` for exactly one clock. `char_out` then holds the data bits, with the first bit received in bit 0 and zeros above the length.
- R8: With `par_en` = 1, the bit after the data is parity. `par_err`, valid with `char_vld`, is 1 when the total count of ones is odd with `par_even` = 1, or even with `par_even` = 0.
- R9: When framed with internal sync, a boundary character equal to `sync1` sets `sync_det` in single-sync mode. In double-sync mode, `sync_det` is set only when two consecutive boundary characters are `sync1` and then `sync2`.
- R10: With `ext_mode` = 1, internal matching is off. A bit strobe with `ext_sync` high sets `sync_det`. If the block is hunting, that strobe also ends the hunt, its bit is discarded, and the first character starts with the next strobe.
- R11: Character length is 5 + `len_sel` bits. Only that many low bits of `sync1` and `sync2` take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per receive-clock rising edge |
| rx_in | input | 1 | Serial data, sampled when `bit_en` is high |
| len_sel | input | 2 | Character length minus 5 |
| par_en | input | 1 | A parity bit follows the data bits |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| one_sync | input | 1 | 1 = single sync character, 0 = two |
| ext_mode | input | 1 | Framing comes from `ext_sync` |
| sync1 | input | 8 | First sync character |
| sync2 | input | 8 | Second sync character |
| hunt_req | input | 1 | Enter-hunt pulse |
| stat_rd | input | 1 | Status-read pulse, clears `sync_det` |
| ext_sync | input | 1 | External sync level |
| char_out | output | 8 | Last assembled character |
| char_vld | output | 1 | One-cycle pulse, a new character is in `char_out` |
| par_err | output | 1 | Parity error of `char_out` |
| sync_det | output | 1 | Sticky sync-detect flag |
| in_hunt | output | 1 | Block is searching for framing |

## Verification
The bench goes after a partial sync pattern that straddles an enter-hunt. A design that skipped the ones fill would report sync halfway into the next character. It also tests a double-sync pair broken by an unrelated character, both in hunt and when framed; a design that only latched "sync1 seen" would set the flag there. Parity mode checks that detection waits for the parity bit, since an early flag would misalign every later character. External mode checks that a window equal to `sync1` is ignored and that the bit under the `ext_sync` strobe is dropped. A design that kept that bit would shift every character by one.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic [1:0] {
      ST_SEEK1 = 2'd0,
      ST_SEEK2 = 2'd1,
      ST_FRAMED = 2'd2
   } shr_state_e;

endpackage

// File: rtl/shr_window.sv
module shr_window #(
   parameter int DATA_W = 8,
   localparam int FW = DATA_W + 1,
   localparam int CW = $clog2(FW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          fill_en,
   input  logic          rx_in,
   input  logic [CW-1:0] span,
   output logic [FW-1:0] win_nx
);

   logic [FW-1:0] win_q;
   logic [FW-1:0] ones_fill;

   always_comb begin
      for (int i = 0; i < FW; i++) begin
         ones_fill[i] = (i < int'(span));
         if (i == int'(span) - 1)
            win_nx[i] = rx_in;
         else if (i < int'(span) - 1)
            win_nx[i] = win_q[i+1];
         else
            win_nx[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= '1;
      else if (fill_en)
         win_q <= ones_fill;
      else if (shift_en)
         win_q <= win_nx;
   end

endmodule

// File: rtl/shr_match.sv
module shr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] pattern,
   input  logic [DATA_W-1:0] care,
   output logic              hit
);

   logic [DATA_W-1:0] diff;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign diff[b] = care[b] & (word[b] ^ pattern[b]);
   end

   assign hit = ~|diff;

endmodule

// File: rtl/shr_bitcnt.sv
module shr_bitcnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] limit,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   assign last = (cnt_q == limit - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + CW'(1);
   end

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   localparam int LEN_SPAN = DATA_W - MIN_LEN + 1,
   localparam int LSEL_W = (LEN_SPAN > 1) ? $clog2(LEN_SPAN) : 1,
   localparam int FW = DATA_W + 1,
   localparam int CW = $clog2(FW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_in,
   input  logic [LSEL_W-1:0] len_sel,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              one_sync,
   input  logic              ext_mode,
   input  logic [DATA_W-1:0] sync1,
   input  logic [DATA_W-1:0] sync2,
   input  logic              hunt_req,
   input  logic              stat_rd,
   input  logic              ext_sync,
   output logic [DATA_W-1:0] char_out,
   output logic              char_vld,
   output logic              par_err,
   output logic              sync_det,
   output logic              in_hunt
);
   import shr_pkg::*;

   if (MIN_LEN < 1 || MIN_LEN > DATA_W) begin : g_bad_len
      $error("sync_hunt_rx: MIN_LEN must lie in 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("sync_hunt_rx: DATA_W must be at least 2");
   end

   logic [CW-1:0]     len_c;
   logic [CW-1:0]     span;
   logic [FW-1:0]     win_nx;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] care;
   logic              pbit;
   logic [1:0]        hit;
   logic              last;
   logic              cnt_clr;
   logic              cnt_step;
   logic              det_set;
   logic              emit;
   logic              arm_q;
   logic              arm_nx;
   shr_state_e        st_q;
   shr_state_e        st_nx;
   logic [DATA_W-1:0] char_q;
   logic              vld_q;
   logic              perr_q;
   logic              det_q;

   always_comb begin
      if (MIN_LEN + int'(len_sel) > DATA_W)
         len_c = CW'(DATA_W);
      else
         len_c = CW'(MIN_LEN + int'(len_sel));
      span = len_c + CW'(par_en);
   end

   shr_window #(.DATA_W(DATA_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_en),
      .fill_en  (hunt_req),
      .rx_in    (rx_in),
      .span     (span),
      .win_nx   (win_nx)
   );

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         care[i] = (i < int'(len_c));
         word[i] = care[i] & win_nx[i];
      end
      pbit = par_en & win_nx[len_c];
   end

   for (genvar k = 0; k < 2; k++) begin : g_cmp
      shr_match #(.DATA_W(DATA_W)) u_match (
         .word    (word),
         .pattern ((k == 0) ? sync1 : sync2),
         .care    (care),
         .hit     (hit[k])
      );
   end

   shr_bitcnt #(.CW(CW)) u_bitcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .step  (cnt_step),
      .limit (span),
      .last  (last)
   );

   always_comb begin
      st_nx    = st_q;
      arm_nx   = arm_q;
      cnt_clr  = 1'b0;
      cnt_step = 1'b0;
      det_set  = 1'b0;
      emit     = 1'b0;
      if (hunt_req) begin
         st_nx   = ST_SEEK1;
         arm_nx  = 1'b0;
         cnt_clr = 1'b1;
      end else if (bit_en) begin
         if (st_q != ST_FRAMED && ext_mode) begin
            if (ext_sync) begin
               st_nx   = ST_FRAMED;
               cnt_clr = 1'b1;
               det_set = 1'b1;
            end
         end else begin
            unique case (st_q)
               ST_SEEK1: begin
                  if (hit[0]) begin
                     cnt_clr = 1'b1;
                     if (one_sync) begin
                        st_nx   = ST_FRAMED;
                        det_set = 1'b1;
                     end else begin
                        st_nx = ST_SEEK2;
                     end
                  end
               end
               ST_SEEK2: begin
                  if (last) begin
                     cnt_clr = 1'b1;
                     if (hit[1]) begin
                        st_nx   = ST_FRAMED;
                        det_set = 1'b1;
                     end else if (!hit[0]) begin
                        st_nx = ST_SEEK1;
                     end
                  end else begin
                     cnt_step = 1'b1;
                  end
               end
               default: begin
                  if (ext_mode && ext_sync)
                     det_set = 1'b1;
                  if (last) begin
                     emit    = 1'b1;
                     cnt_clr = 1'b1;
                     if (!ext_mode) begin
                        if (one_sync) begin
                           if (hit[0])
                              det_set = 1'b1;
                        end else begin
                           if (arm_q && hit[1])
                              det_set = 1'b1;
                           arm_nx = hit[0];
                        end
                     end
                  end else begin
                     cnt_step = 1'b1;
                  end
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_SEEK1;
         arm_q  <= 1'b0;
         det_q  <= 1'b0;
         vld_q  <= 1'b0;
         char_q <= '0;
         perr_q <= 1'b0;
      end else begin
         st_q  <= st_nx;
         arm_q <= arm_nx;
         vld_q <= emit;
         if (det_set)
            det_q <= 1'b1;
         else if (stat_rd)
            det_q <= 1'b0;
         if (emit) begin
            char_q <= word;
            perr_q <= par_en & ((^word) ^ pbit ^ ~par_even);
         end
      end
   end

   assign char_out = char_q;
   assign char_vld = vld_q;
   assign par_err  = perr_q;
   assign sync_det = det_q;
   assign in_hunt  = (st_q != ST_FRAMED);

endmodule

// File: rtl/shr_chk.sv
module shr_chk #(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   localparam int LEN_SPAN = DATA_W - MIN_LEN + 1,
   localparam int LSEL_W = (LEN_SPAN > 1) ? $clog2(LEN_SPAN) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic [LSEL_W-1:0] len_sel,
   input logic              hunt_req,
   input logic              stat_rd,
   input logic [DATA_W-1:0] char_out,
   input logic              char_vld,
   input logic              sync_det,
   input logic              in_hunt
);

   logic [DATA_W-1:0] above_len;

   always_comb begin
      for (int i = 0; i < DATA_W; i++)
         above_len[i] = (i >= MIN_LEN + int'(len_sel)) & char_out[i];
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (in_hunt && !sync_det && !char_vld));

   assert_hunt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |=> (in_hunt && !char_vld));

   assert_det_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_det) |-> $past(bit_en));

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !bit_en) |=> (!sync_det && $stable(in_hunt)));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |=> !char_vld);

   assert_framed_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |-> !in_hunt);

   assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |-> (above_len == '0));

endmodule

bind sync_hunt_rx shr_chk #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_shr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .len_sel  (len_sel),
   .hunt_req (hunt_req),
   .stat_rd  (stat_rd),
   .char_out (char_out),
   .char_vld (char_vld),
   .sync_det (sync_det),
   .in_hunt  (in_hunt)
);

// File: tb/tb_sync_hunt_rx.sv
module tb_sync_hunt_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] len_sel = 2'd3;
   logic       par_en = 1'b0;
   logic       par_even = 1'b1;
   logic       one_sync = 1'b0;
   logic       ext_mode = 1'b0;
   logic [7:0] sync1 = 8'h3C;
   logic [7:0] sync2 = 8'hA5;
   logic       hunt_req = 1'b0;
   logic       stat_rd = 1'b0;
   logic       ext_sync = 1'b0;
   logic [7:0] char_out;
   logic       char_vld;
   logic       par_err;
   logic       sync_det;
   logic       in_hunt;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  started = 0;
   bit  done = 0;
   int  last_char = -1;
   bit  last_perr = 0;

   // reference model state
   int  mst = 0;
   int  mcnt = 0;
   bit  marm = 0;
   bit  mdet = 0;
   bit  mvld = 0;
   bit  mperr = 0;
   int  mchar = 0;
   bit  hist[$];

   sync_hunt_rx dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_in    (rx_in),
      .len_sel  (len_sel),
      .par_en   (par_en),
      .par_even (par_even),
      .one_sync (one_sync),
      .ext_mode (ext_mode),
      .sync1    (sync1),
      .sync2    (sync2),
      .hunt_req (hunt_req),
      .stat_rd  (stat_rd),
      .ext_sync (ext_sync),
      .char_out (char_out),
      .char_vld (char_vld),
      .par_err  (par_err),
      .sync_det (sync_det),
      .in_hunt  (in_hunt)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int mdata(output int pb);
      int l = 5 + int'(len_sel);
      int w = l + int'(par_en);
      int n = hist.size();
      int d = 0;
      for (int i = 0; i < l; i++)
         d |= int'(hist[n - w + i]) << i;
      pb = par_en ? int'(hist[n - w + l]) : 0;
      return d;
   endfunction

   task automatic refill();
      hist.delete();
      for (int i = 0; i < 9; i++) hist.push_back(1'b1);
   endtask

   initial refill();

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      int d, pb, l, w, lm, ones;
      bit h1, h2, last, set, emit;
      l = 5 + int'(len_sel);
      w = l + int'(par_en);
      lm = (1 << l) - 1;
      set = 0;
      emit = 0;
      d = 0;
      pb = 0;
      if (!rst_n) begin
         refill();
         mst = 0; mcnt = 0; marm = 0; mdet = 0; mvld = 0; mperr = 0; mchar = 0;
      end else begin
         if (hunt_req) begin
            refill();
            mst = 0; mcnt = 0; marm = 0;
         end else if (bit_en) begin
            hist.push_back(rx_in);
            if (hist.size() > 40) void'(hist.pop_front());
            d = mdata(pb);
            h1 = (d == (int'(sync1) & lm));
            h2 = (d == (int'(sync2) & lm));
            last = (mcnt == w - 1);
            if (mst != 2 && ext_mode) begin
               if (ext_sync) begin mst = 2; mcnt = 0; set = 1; end
            end else if (mst == 0) begin
               if (h1) begin
                  mcnt = 0;
                  if (one_sync) begin mst = 2; set = 1; end
                  else mst = 1;
               end
            end else if (mst == 1) begin
               if (last) begin
                  mcnt = 0;
                  if (h2) begin mst = 2; set = 1; end
                  else if (!h1) mst = 0;
               end else mcnt++;
            end else begin
               if (ext_mode && ext_sync) set = 1;
               if (last) begin
                  emit = 1;
                  mcnt = 0;
                  if (!ext_mode) begin
                     if (one_sync) begin
                        if (h1) set = 1;
                     end else begin
                        if (marm && h2) set = 1;
                        marm = h1;
                     end
                  end
               end else mcnt++;
            end
         end
         if (set) mdet = 1;
         else if (stat_rd) mdet = 0;
         mvld = emit;
         if (emit) begin
            mchar = d;
            ones = $countones(d) + pb;
            mperr = par_en && (par_even ? (ones % 2 == 1) : (ones % 2 == 0));
         end
      end
   end

   // compare against the model on every clock, away from the rising edge
   always @(negedge clk) begin
      if (started && !done) begin
         check(sync_det == mdet, "R5 sync_det vs model", sync_det, mdet);
         check(in_hunt == (mst != 2), "R3 in_hunt vs model", in_hunt, mst != 2);
         check(char_vld == mvld, "R7 char_vld vs model", char_vld, mvld);
         if (mvld) begin
            check(int'(char_out) == mchar, "R7 char_out vs model", char_out, mchar);
            check(par_err == mperr, "R8 par_err vs model", par_err, mperr);
         end
      end
      if (char_vld) begin
         last_char = int'(char_out);
         last_perr = par_err;
      end
   end

   task automatic send_bit(input bit b, input bit x = 0);
      @(negedge clk);
      rx_in = b;
      ext_sync = x;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      ext_sync = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_char(input int v, input int n);
      for (int i = 0; i < n; i++) send_bit(v[i]);
   endtask

   task automatic pulse_hunt();
      @(negedge clk); hunt_req = 1'b1;
      @(negedge clk); hunt_req = 1'b0;
   endtask

   task automatic pulse_read();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      started = 1;
      check(in_hunt == 1 && sync_det == 0 && char_vld == 0, "R1 reset state",
            {in_hunt, sync_det, char_vld}, 3'b100);
      rst_n = 1'b1;

      // double sync, 8 bits, no parity
      pulse_hunt();
      send_bit(1); send_bit(0); send_bit(1);
      send_char(8'h3C, 8);
      check(in_hunt == 1, "R4 waiting for sync2", in_hunt, 1);
      send_char(8'hA5, 8);
      check(sync_det == 1 && in_hunt == 0, "R5 double sync found", {sync_det, in_hunt}, 2'b10);
      pulse_read();
      check(sync_det == 0 && in_hunt == 0, "R6 read clears flag only", {sync_det, in_hunt}, 2'b00);
      send_char(8'h12, 8);
      check(last_char == 8'h12, "R7 first framed char", last_char, 8'h12);
      send_char(8'h3C, 8);
      send_char(8'hA5, 8);
      check(sync_det == 1, "R9 framed sync pair", sync_det, 1);
      pulse_read();
      send_char(8'h3C, 8);
      send_char(8'h77, 8);
      send_char(8'hA5, 8);
      check(sync_det == 0, "R9 broken pair while framed", sync_det, 0);

      // broken pair during hunt
      pulse_hunt();
      send_char(8'h3C, 8);
      send_char(8'h77, 8);
      send_char(8'hA5, 8);
      check(in_hunt == 1 && sync_det == 0, "R4 non-contiguous pair", {in_hunt, sync_det}, 2'b10);

      // 7 bits, even parity, single sync, upper pattern bit set
      len_sel = 2'd2; par_en = 1'b1; par_even = 1'b1; one_sync = 1'b1; sync1 = 8'h96;
      pulse_hunt();
      send_char(7'h16, 7);
      check(sync_det == 0, "R5 waits for parity bit", sync_det, 0);
      send_bit(1);
      check(sync_det == 1, "R11 masked sync found", sync_det, 1);
      send_char(7'h55, 7); send_bit(0);
      check(last_char == 8'h55 && last_perr == 0, "R8 good parity", {last_perr, 8'(last_char)}, 9'h055);
      send_char(7'h2A, 7); send_bit(0);
      check(last_char == 8'h2A && last_perr == 1, "R8 bad parity", {last_perr, 8'(last_char)}, 9'h12A);
      par_even = 1'b0;
      send_char(7'h2A, 7); send_bit(0);
      check(last_perr == 0, "R8 odd parity good", last_perr, 0);

      // ones fill on enter-hunt
      len_sel = 2'd3; par_en = 1'b0; one_sync = 1'b1; sync1 = 8'hF0;
      pulse_read();
      pulse_hunt();
      send_bit(0); send_bit(0); send_bit(0); send_bit(0);
      pulse_hunt();
      send_bit(1); send_bit(1); send_bit(1); send_bit(1);
      check(in_hunt == 1 && sync_det == 0, "R2 stale bits discarded", {in_hunt, sync_det}, 2'b10);
      send_bit(0); send_bit(0); send_bit(0); send_bit(0);
      send_bit(1); send_bit(1); send_bit(1); send_bit(1);
      check(sync_det == 1 && in_hunt == 0, "R3 match at any bit", {sync_det, in_hunt}, 2'b10);

      // external framing, 5 bits
      len_sel = 2'd0; ext_mode = 1'b1; sync1 = 8'h15;
      pulse_read();
      pulse_hunt();
      send_char(5'h15, 5);
      check(in_hunt == 1 && sync_det == 0, "R10 internal match disabled", {in_hunt, sync_det}, 2'b10);
      send_bit(1, 1);
      check(in_hunt == 0 && sync_det == 1, "R10 external sync", {in_hunt, sync_det}, 2'b01);
      send_char(5'h0B, 5);
      check(last_char == 8'h0B, "R10 assembly after strobe", last_char, 8'h0B);
      send_char(5'h1E, 5);
      check(last_char == 8'h1E, "R7 second ext char", last_char, 8'h1E);

      // reset in the middle of a run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(in_hunt == 1 && sync_det == 0, "R1 reset mid-run", {in_hunt, sync_det}, 2'b10);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule